// File: doc/BRIEF.md
# Quantum-Based Fetch Policy Switcher

This controller watches the throughput of a multithreaded core over fixed windows of `QUANTUM_CYCLES` clock cycles. During each window it adds up the instructions committed and counts four kinds of pressure event: level-one cache misses, cycles with a full load/store queue, branch mispredictions and conditional branches. The core reports these every cycle.

On the last cycle of a window it compares the totals with thresholds supplied on input ports. Configuration logic outside the block can rewrite those thresholds at any time. If the window was low-throughput and throughput did not rise from the previous window, the controller chooses a new fetch policy. The choice depends on the policy now in force and on two derived flags, memory pressure and branch pressure. The active policy code goes to the thread arbiter. A one-cycle pulse marks every change.

Top module: `fetch_policy_switcher`

## Requirements
- R1: After reset the policy output is 0 (instruction-count policy) and the switch pulse is low. Codes: 0 instruction-count, 1 cache-miss-count, 2 branch-count.
- R2: The policy changes only on the clock edge that closes a window of QUANTUM_CYCLES cycles, counted from reset release.
- R3: A window is low-throughput when its commit total is strictly below `ipc_thr_i`. At or above the threshold, no switch occurs.
- R4: A low window causes no switch when its commit total is strictly greater than the previous window's total. The first window after reset has no previous total.
- R5: Memory pressure holds when the miss count is strictly above `miss_thr_i` or the queue-full count is strictly above `lsqf_thr_i`.
- R6: Branch pressure holds when the mispredict count is strictly above `misp_thr_i` or the conditional-branch count is strictly above `cbr_thr_i`.
- R7: From policy 0, a switch goes to 2 under branch pressure and to 1 otherwise.
- R8: From policy 1, a switch goes to 2 under branch pressure and to 0 otherwise.
- R9: From policy 2, a switch goes to 1 under memory pressure and to 0 otherwise.
- R10: `switch_o` is high for exactly the one cycle after the edge on which the policy changed.
- R11: All window counters restart at each window boundary. Thresholds are taken at their current value on the closing cycle, so a threshold changed at run time applies to the next decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_i | input | COMMIT_W | Instructions committed this cycle |
| l1_miss_i | input | 1 | Level-one miss event this cycle |
| lsq_full_i | input | 1 | Load/store queue full this cycle |
| mispred_i | input | 1 | Branch mispredict this cycle |
| cond_br_i | input | 1 | Conditional branch this cycle |
| ipc_thr_i | input | CNT_W | Commit-total threshold per window |
| miss_thr_i | input | EV_W | Miss-count threshold per window |
| lsqf_thr_i | input | EV_W | Queue-full threshold per window |
| misp_thr_i | input | EV_W | Mispredict threshold per window |
| cbr_thr_i | input | EV_W | Conditional-branch threshold per window |
| policy_o | output | 2 | Active fetch policy code |
| switch_o | output | 1 | One-cycle pulse on a policy change |

## Verification
The case that is hardest to reach from the ports is a window that is low-throughput but is still held back because its commit total rose from the previous one. Reaching it takes two windows in a row, each with a chosen exact total. The stimulus therefore sets a per-cycle commit rate plus a count of cycles that commit one extra instruction. This gives exact totals such as 64, 74 and 127. With these it walks every transition edge, both strict-inequality boundaries and a threshold rewritten between windows.

// File: rtl/fetch_policy_switcher.sv
module fetch_policy_switcher #(
  parameter int QUANTUM_CYCLES = 8192,
  parameter int COMMIT_W       = 4,
  localparam int Q_W   = $clog2(QUANTUM_CYCLES),
  localparam int EV_W  = $clog2(QUANTUM_CYCLES + 1),
  localparam int CNT_W = $clog2(QUANTUM_CYCLES * ((1 << COMMIT_W) - 1) + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [COMMIT_W-1:0] commit_i,
  input  logic                l1_miss_i,
  input  logic                lsq_full_i,
  input  logic                mispred_i,
  input  logic                cond_br_i,
  input  logic [CNT_W-1:0]    ipc_thr_i,
  input  logic [EV_W-1:0]     miss_thr_i,
  input  logic [EV_W-1:0]     lsqf_thr_i,
  input  logic [EV_W-1:0]     misp_thr_i,
  input  logic [EV_W-1:0]     cbr_thr_i,
  output logic [1:0]          policy_o,
  output logic                switch_o
);

  localparam logic [1:0] POL_ICNT = 2'd0;
  localparam logic [1:0] POL_MISS = 2'd1;
  localparam logic [1:0] POL_BRCH = 2'd2;

  logic [Q_W-1:0]   q_cnt;
  logic [CNT_W-1:0] commit_acc, prev_commit;
  logic [EV_W-1:0]  miss_acc, lsqf_acc, misp_acc, cbr_acc;
  logic             has_prev;
  logic [1:0]       policy_q, policy_nx;
  logic             sw_q;

  wire              q_end      = (q_cnt == Q_W'(QUANTUM_CYCLES - 1));
  wire [CNT_W-1:0]  commit_sum = commit_acc + CNT_W'(commit_i);
  wire [EV_W-1:0]   miss_sum   = miss_acc + EV_W'(l1_miss_i);
  wire [EV_W-1:0]   lsqf_sum   = lsqf_acc + EV_W'(lsq_full_i);
  wire [EV_W-1:0]   misp_sum   = misp_acc + EV_W'(mispred_i);
  wire [EV_W-1:0]   cbr_sum    = cbr_acc + EV_W'(cond_br_i);

  wire low_tput  = commit_sum < ipc_thr_i;
  wire rising    = has_prev && (commit_sum > prev_commit);
  wire mem_press = (miss_sum > miss_thr_i) || (lsqf_sum > lsqf_thr_i);
  wire br_press  = (misp_sum > misp_thr_i) || (cbr_sum > cbr_thr_i);
  wire do_switch = q_end && low_tput && !rising;

  always_comb begin
    case (policy_q)
      POL_ICNT: policy_nx = br_press  ? POL_BRCH : POL_MISS;
      POL_MISS: policy_nx = br_press  ? POL_BRCH : POL_ICNT;
      POL_BRCH: policy_nx = mem_press ? POL_MISS : POL_ICNT;
      default:  policy_nx = POL_ICNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_cnt       <= '0;
      commit_acc  <= '0;
      miss_acc    <= '0;
      lsqf_acc    <= '0;
      misp_acc    <= '0;
      cbr_acc     <= '0;
      prev_commit <= '0;
      has_prev    <= 1'b0;
    end else if (q_end) begin
      q_cnt       <= '0;
      commit_acc  <= '0;
      miss_acc    <= '0;
      lsqf_acc    <= '0;
      misp_acc    <= '0;
      cbr_acc     <= '0;
      prev_commit <= commit_sum;
      has_prev    <= 1'b1;
    end else begin
      q_cnt      <= q_cnt + 1'b1;
      commit_acc <= commit_sum;
      miss_acc   <= miss_sum;
      lsqf_acc   <= lsqf_sum;
      misp_acc   <= misp_sum;
      cbr_acc    <= cbr_sum;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      policy_q <= POL_ICNT;
      sw_q     <= 1'b0;
    end else begin
      sw_q <= do_switch;
      if (do_switch) policy_q <= policy_nx;
    end
  end

  assign policy_o = policy_q;
  assign switch_o = sw_q;

  AST_POLICY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    policy_q != 2'd3); // R1
  AST_MID_QUANTUM_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt != '0) |-> $stable(policy_q)); // R2
  AST_PULSE_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    switch_o |-> (policy_q != $past(policy_q))); // R10
  AST_RISING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (q_end && rising) |=> !switch_o); // R4
  AST_HIGH_TPUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (q_end && !low_tput) |=> $stable(policy_q)); // R3

endmodule

// File: tb/fetch_policy_switcher_tb_top.sv
module fetch_policy_switcher_tb_top;
  localparam int Q = 64;
  localparam int CW = 4;
  localparam int EVW = 7;
  localparam int CNW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] commit_i = '0;
  logic l1_miss_i = 0, lsq_full_i = 0, mispred_i = 0, cond_br_i = 0;
  logic [CNW-1:0] ipc_thr_i = 10'd128;
  logic [EVW-1:0] miss_thr_i = 7'd12, lsqf_thr_i = 7'd29, misp_thr_i = 7'd1, cbr_thr_i = 7'd24;
  logic [1:0] policy_o;
  logic switch_o;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  fetch_policy_switcher #(.QUANTUM_CYCLES(Q), .COMMIT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .commit_i(commit_i), .l1_miss_i(l1_miss_i),
    .lsq_full_i(lsq_full_i), .mispred_i(mispred_i), .cond_br_i(cond_br_i),
    .ipc_thr_i(ipc_thr_i), .miss_thr_i(miss_thr_i), .lsqf_thr_i(lsqf_thr_i),
    .misp_thr_i(misp_thr_i), .cbr_thr_i(cbr_thr_i),
    .policy_o(policy_o), .switch_o(switch_o));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_q(string req, int cpc, int extra, int nmiss, int nlsq,
                       int nmisp, int ncbr, int exp_pol, int exp_sw);
    int pol_before;
    pol_before = policy_o;
    for (int i = 0; i < Q; i++) begin
      commit_i   = CW'(cpc + ((i < extra) ? 1 : 0));
      l1_miss_i  = (i < nmiss);
      lsq_full_i = (i < nlsq);
      mispred_i  = (i < nmisp);
      cond_br_i  = (i < ncbr);
      @(negedge clk);
      if (i == 0) chk({req, " R10 pulse low in window"}, switch_o, 0);
      if (i == Q/2) chk({req, " R2 policy held mid-window"}, policy_o, pol_before);
    end
    chk({req, " policy"}, policy_o, exp_pol);
    chk({req, " R10 switch pulse"}, switch_o, exp_sw);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset policy", policy_o, 0);
    chk("R1 reset switch", switch_o, 0);
    rst_n = 1'b1;
    run_q("R3 high tput first window", 3, 0, 0, 0, 0, 0, 0, 0);
    run_q("R7 icnt no branch", 1, 0, 0, 0, 0, 0, 1, 1);
    run_q("R8 miss branch via cbr, R4 equal total", 1, 0, 0, 0, 0, 30, 2, 1);
    run_q("R4 rising total blocks", 1, 10, 0, 0, 0, 0, 2, 0);
    run_q("R9 R5 brch mem via miss", 1, 0, 13, 0, 0, 0, 1, 1);
    run_q("R8 miss no branch", 1, 0, 0, 0, 0, 0, 0, 1);
    run_q("R7 R6 icnt branch via misp", 1, 0, 0, 0, 2, 0, 2, 1);
    run_q("R5 R9 mem at exact thresholds", 1, 0, 12, 29, 0, 0, 0, 1);
    run_q("R6 R7 branch at exact thresholds", 1, 0, 0, 0, 1, 24, 1, 1);
    run_q("R8 branch via cbr", 1, 0, 0, 0, 0, 25, 2, 1);
    run_q("R9 R11 mem via lsq", 1, 0, 0, 30, 0, 0, 1, 1);
    run_q("R3 R11 high tput events cleared", 3, 0, 0, 0, 0, 0, 1, 0);
    run_q("R3 total equals threshold", 2, 0, 0, 0, 0, 0, 1, 0);
    run_q("R3 one below threshold", 1, 63, 0, 0, 0, 0, 0, 1);
    ipc_thr_i = 10'd256;
    run_q("R11 R4 new threshold rising blocks", 3, 0, 0, 0, 0, 0, 0, 0);
    run_q("R11 new threshold applies", 3, 0, 0, 0, 0, 0, 1, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule